// File: doc/BRIEF.md
# Retired Instruction Counter CSR

This block holds the 64-bit count of instructions that a hart has retired and exposes it as a machine-mode CSR. Each cycle it sees when an instruction begins, when an instruction retires, the current value of the instruction-retired inhibit bit, and any CSR write with its address and data. From these it decides whether the retiring instruction adds one to the count. The inhibit bit is captured when an instruction begins. A write that the instruction itself makes to the inhibit control therefore only governs later instructions. An instruction that writes the counter replaces its value and does not also count itself.

The parameter `XLEN` selects a 32-bit or a 64-bit configuration. With 32-bit CSRs the upper half of the counter has its own address. A combinational read port returns the half that the read address selects. The value it returns is the one held at the start of the cycle.

No stream flows through the block, so no port uses valid/ready. Every pin is a plain control or data level, sampled on the rising clock edge. Each instruction must raise `insn_start` in its first cycle. The only exception is an instruction already in flight when reset is released, which counts by default.

Top module: `rir_counter_csr`

## Requirements
- R1: After reset the count is zero and counting is enabled, so a retire pulse with no preceding `insn_start` adds one.
- R2: A write to address 0xB02 replaces the low XLEN bits of the count on the next clock edge.
- R3: With XLEN = 32, a write to address 0xB82 replaces bits 63..32. A write to either half leaves the other half unchanged.
- R4: If an instruction writes the counter, at 0xB02 or at a mapped 0xB82, in any of its cycles up to and including its retire cycle, the written value is kept and that instruction adds nothing.
- R5: A retire with counting enabled adds exactly one, carrying from bit 31 into bit 32. The count wraps from all ones to zero.
- R6: The inhibit bit (1 = do not count) is sampled in the cycle `insn_start` is high. Later changes to it do not affect that instruction but do apply to the next one.
- R7: Cycles without a retire pulse and without a counter write leave the count unchanged. This includes an instruction that starts and never retires.
- R8: A read at 0xB02 returns the low XLEN bits and a read at 0xB82 (XLEN = 32) returns bits 63..32. Both return the value from before any same-cycle update. Any other read address returns zero.
- R9: With XLEN = 64, address 0xB82 is not mapped. Writes to it change nothing and do not cancel an increment, and reads from it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_start | input | 1 | First cycle of an instruction; samples the inhibit bit |
| inhibit_ir | input | 1 | Current instruction-retired inhibit bit, 1 stops counting |
| retire | input | 1 | The current instruction retires this cycle |
| csr_we | input | 1 | CSR write strobe |
| csr_waddr | input | 12 | CSR write address |
| csr_wdata | input | XLEN | CSR write data |
| csr_raddr | input | 12 | CSR read address |
| csr_rdata | output | XLEN | Read data, the selected half of the count |

## Verification
The assertions assume that all inputs are free of unknowns once reset is released. They also assume that a counter write and a retire pulse may share a cycle, and that the write then wins. They do not assume that `insn_start` and `retire` alternate in any fixed pattern. The stimulus drives every input on the falling edge and returns the strobes to zero after one cycle. It covers instructions that take one cycle, that take several cycles, and that never retire, so every mix the assertions must accept occurs without leaving those assumptions.

// File: rtl/rir_pkg.sv
package rir_pkg;
  localparam int CNT_W = 64;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 12'hB02;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 12'hB82;

  typedef struct packed {
    logic lo;
    logic hi;
  } half_wr_t;
endpackage

// File: rtl/rir_incr_gate.sv
module rir_incr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic insn_start,
  input  logic inhibit_ir,
  input  logic cnt_write,
  input  logic retire,
  output logic bump
);
  logic en_q;
  logic en_eff;

  // The inhibit value is taken at instruction start; otherwise the latched flag holds.
  assign en_eff = insn_start ? ~inhibit_ir : en_q;
  assign bump   = retire & en_eff & ~cnt_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_eff & ~cnt_write;
  end

  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_write |=> !(retire && !insn_start && !cnt_write && bump)); // R4
endmodule

// File: rtl/rir_count_reg.sv
module rir_count_reg
  import rir_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  half_wr_t         wr,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] cnt
);
  localparam int HALF_W = CNT_W / 2;
  logic [CNT_W-1:0] cnt_nxt;

  generate
    if (XLEN == 32) begin : g_split
      always_comb begin
        cnt_nxt = cnt;
        if (bump) cnt_nxt = cnt + 64'd1;
        if (wr.lo) cnt_nxt[HALF_W-1:0] = wdata[HALF_W-1:0];
        if (wr.hi) cnt_nxt[CNT_W-1:HALF_W] = wdata[HALF_W-1:0];
      end

      AST_WRITE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        wr.hi |=> cnt[CNT_W-1:HALF_W] == $past(wdata[HALF_W-1:0])); // R3
      AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr.lo && !wr.hi |=> cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W])); // R3
      AST_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr.hi && !wr.lo |=> cnt[HALF_W-1:0] == $past(cnt[HALF_W-1:0])); // R3
    end else begin : g_full
      always_comb begin
        cnt_nxt = cnt;
        if (bump)  cnt_nxt = cnt + 64'd1;
        if (wr.lo) cnt_nxt[XLEN-1:0] = wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr.lo |=> cnt[XLEN-1:0] == $past(wdata)); // R2
  AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    bump && !wr.lo && !wr.hi |=> cnt == $past(cnt) + 64'd1); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bump && !wr.lo && !wr.hi |=> $stable(cnt)); // R7
endmodule

// File: rtl/rir_counter_csr.sv
module rir_counter_csr
  import rir_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_start,
  input  logic              inhibit_ir,
  input  logic              retire,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_waddr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [ADDR_W-1:0] csr_raddr,
  output logic [XLEN-1:0]   csr_rdata
);
  localparam bit HAS_HI = (XLEN == 32);

  half_wr_t         wr;
  logic             cnt_write;
  logic             bump;
  logic [CNT_W-1:0] cnt;

  assign wr.lo     = csr_we && (csr_waddr == ADDR_CNT_LO);
  assign wr.hi     = HAS_HI && csr_we && (csr_waddr == ADDR_CNT_HI);
  assign cnt_write = wr.lo | wr.hi;

  rir_incr_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_start (insn_start),
    .inhibit_ir (inhibit_ir),
    .cnt_write  (cnt_write),
    .retire     (retire),
    .bump       (bump)
  );

  rir_count_reg #(.XLEN(XLEN)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (bump),
    .wr    (wr),
    .wdata (csr_wdata),
    .cnt   (cnt)
  );

  generate
    if (HAS_HI) begin : g_rd32
      always_comb begin
        if (csr_raddr == ADDR_CNT_LO)      csr_rdata = cnt[XLEN-1:0];
        else if (csr_raddr == ADDR_CNT_HI) csr_rdata = cnt[CNT_W-1:XLEN];
        else                               csr_rdata = '0;
      end
    end else begin : g_rd64
      always_comb begin
        if (csr_raddr == ADDR_CNT_LO) csr_rdata = cnt[XLEN-1:0];
        else                          csr_rdata = '0;
      end
    end
  endgenerate

  AST_XLEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (XLEN == 32) || (XLEN == 64)); // R9
  AST_HI_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_HI && csr_raddr == ADDR_CNT_HI |-> csr_rdata == '0); // R9
endmodule

// File: tb/rir_counter_csr_tb.sv
module rir_counter_csr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        st = 0, inh = 0, rt = 0, we = 0;
  logic [11:0] wa = 0, ra = 0;
  logic [31:0] wd = 0;
  logic [31:0] rd;

  logic        st_w = 0, rt_w = 0, we_w = 0;
  logic [11:0] wa_w = 0, ra_w = 0;
  logic [63:0] wd_w = 0;
  logic [63:0] rd_w;

  int checks = 0, errors = 0;

  rir_counter_csr #(.XLEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_start(st), .inhibit_ir(inh), .retire(rt),
    .csr_we(we), .csr_waddr(wa), .csr_wdata(wd), .csr_raddr(ra), .csr_rdata(rd));

  rir_counter_csr #(.XLEN(64)) u_dut64 (
    .clk(clk), .rst_n(rst_n), .insn_start(st_w), .inhibit_ir(1'b0), .retire(rt_w),
    .csr_we(we_w), .csr_waddr(wa_w), .csr_wdata(wd_w), .csr_raddr(ra_w), .csr_rdata(rd_w));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle, driven after a falling edge, strobes dropped after it
  task automatic cyc(input logic s, input logic r, input logic i,
                     input logic w, input logic [11:0] a, input logic [31:0] d);
    st = s; rt = r; inh = i; we = w; wa = a; wd = d;
    @(negedge clk);
    st = 0; rt = 0; we = 0;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    ra = 12'hB02; #1 v[31:0] = rd;
    ra = 12'hB82; #1 v[63:32] = rd;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd_cnt(v); chk("R1 reset zero", v, 64'd0);
    cyc(0, 1, 0, 0, 0, 0);
    rd_cnt(v); chk("R1 enabled by default", v, 64'd1);
  endtask

  task automatic t_count;
    logic [63:0] v;
    for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, 0, 0);
    rd_cnt(v); chk("R5 plain increments", v, 64'd4);
  endtask

  task automatic t_inhibit;
    logic [63:0] v;
    cyc(1, 1, 1, 0, 0, 0);
    rd_cnt(v); chk("R6 inhibited single cycle", v, 64'd4);
    cyc(1, 0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0);
    rd_cnt(v); chk("R6 cleared mid-instruction, old setting", v, 64'd4);
    cyc(1, 0, 0, 0, 0, 0); cyc(0, 1, 1, 0, 0, 0);
    rd_cnt(v); chk("R6 set mid-instruction, still counted", v, 64'd5);
    cyc(1, 1, 1, 0, 0, 0);
    rd_cnt(v); chk("R6 new setting on next instruction", v, 64'd5);
    inh = 0;
  endtask

  task automatic t_write;
    logic [63:0] v;
    cyc(1, 1, 0, 1, 12'hB02, 32'd100);
    rd_cnt(v); chk("R4 R2 same-cycle low write", v, 64'd100);
    cyc(1, 0, 0, 0, 0, 0); cyc(0, 0, 0, 1, 12'hB82, 32'd7); cyc(0, 1, 0, 0, 0, 0);
    rd_cnt(v); chk("R4 R3 earlier high write cancels", v, {32'd7, 32'd100});
  endtask

  task automatic t_trap;
    logic [63:0] v;
    cyc(1, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    rd_cnt(v); chk("R7 no retire no change", v, {32'd7, 32'd100});
    cyc(1, 1, 0, 0, 0, 0);
    rd_cnt(v); chk("R7 next instruction counts", v, {32'd7, 32'd101});
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    cyc(0, 0, 0, 1, 12'hB02, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 1, 12'hB82, 32'd2);
    rd_cnt(v); chk("R3 halves written apart", v, {32'd2, 32'hFFFF_FFFF});
    cyc(1, 1, 0, 0, 0, 0);
    rd_cnt(v); chk("R5 carry into high half", v, {32'd3, 32'd0});
    cyc(0, 0, 0, 1, 12'hB82, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 1, 12'hB02, 32'hFFFF_FFFF);
    cyc(1, 1, 0, 0, 0, 0);
    rd_cnt(v); chk("R5 wrap to zero", v, 64'd0);
  endtask

  task automatic t_read;
    ra = 12'hB02; st = 1; rt = 1;
    #1 chk("R8 pre-update read", {32'd0, rd}, 64'd0);
    @(negedge clk); st = 0; rt = 0;
    #1 chk("R8 post-update read", {32'd0, rd}, 64'd1);
    ra = 12'hB00; #1 chk("R8 other address zero", {32'd0, rd}, 64'd0);
  endtask

  task automatic t_wide;
    we_w = 1; wa_w = 12'hB02; wd_w = 64'h0123_4567_89AB_CDEF;
    @(negedge clk); we_w = 0;
    ra_w = 12'hB02; #1 chk("R2 full-width write", rd_w, 64'h0123_4567_89AB_CDEF);
    st_w = 1; rt_w = 1; we_w = 1; wa_w = 12'hB82; wd_w = 64'd5;
    @(negedge clk); st_w = 0; rt_w = 0; we_w = 0;
    #1 chk("R9 unmapped write ignored, still counts", rd_w, 64'h0123_4567_89AB_CDF0);
    ra_w = 12'hB82; #1 chk("R9 unmapped read zero", rd_w, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_inhibit();
    t_write();
    t_trap();
    t_wrap();
    t_read();
    t_wide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule